// File: doc/BRIEF.md
# Per-Core Two-Stage Tick Timer

This block is the local event timer for one processor core. A prescaler stage counts tick-enable pulses down from a programmed reload value. Each time it wraps, it advances a second stage: an interrupt counter that was loaded from an interrupt-count buffer. When the interrupt counter runs out, the block latches a pending event and, if that event is enabled, drives its interrupt output. In interval mode the interrupt counter reloads from its buffer and the timer keeps running. Otherwise the interrupt-start control clears itself and the timer produces a single event.

Software programs the block through a simple 32-bit register bus. The bus has a write strobe, a byte address, write data and combinational read data. Every write is accepted in the cycle it is presented, so the bus has no back-pressure. Writes to the reload, count buffer and control registers pass through a fixed pipeline of `WR_DELAY` cycles before they take effect. Each such write raises a write-status bit when it lands, and software clears that bit by writing 1 to it. Writes to the status, enable and write-status registers take effect on the next clock edge. Reads return the value the register holds at that moment.

Top module: `core_tick_timer`

## Requirements
- R1: After reset, every register reads 0 and `irq` is low.
- R2: A write to the reload register (0x00), the count buffer (0x08) or the control register (0x20) changes nothing for `WR_DELAY` clock edges. It takes effect on the edge `WR_DELAY` after the edge that captured it, and a readback before that edge returns the old value.
- R3: In the write-status register (0x40), bit 0 is set when a reload write lands, bit 1 when a count-buffer write lands, and bit 3 when a control write lands. Writing 1 to a bit clears it. Writing 0 leaves it unchanged.
- R4: A count-buffer write whose bit 31 is 0 leaves the buffer and the interrupt counter unchanged, but it still sets write-status bit 1. When bit 31 is 1, bits 30:0 are loaded into both the buffer and the interrupt counter. The buffer reads back with bit 31 as 0.
- R5: Landing a reload write also loads the prescaler count. While control bit 0 is set, each `tick_en` pulse decrements the count, and the stage wraps once every reload+1 pulses. While control bit 0 is clear, `tick_en` has no effect.
- R6: While control bit 1 is set, the interrupt counter decrements once per prescaler wrap. The event fires on the wrap that finds the counter at 1 (or 0), so a buffer value N ≥ 1 fires after exactly N wraps. The event sets bit 0 of the status register (0x30). While control bit 1 is clear, wraps do not advance the counter.
- R7: With control bit 2 clear (one-shot), the event clears control bit 1. No further event follows until software sets bit 1 again.
- R8: With control bit 2 set (interval), the event reloads the interrupt counter from the buffer. The next event then follows N wraps later.
- R9: Writing 1 to status bit 0 clears the pending event.
- R10: `irq` is high exactly when status bit 0 and enable bit 0 (register 0x34) are both 1.
- R11: With both control bits 0 and 1 clear, no event is produced, whatever `tick_en` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe; the write is accepted on this edge |
| bus_addr | input | 8 | Register byte address for the write and the read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| tick_en | input | 1 | Prescaler count pulse, one per cycle when high |
| irq | output | 1 | Interrupt request, level |

## Verification
The two-stage timing is checked with several pairs of reload and count values, in one-shot mode and in interval mode. In each case the bench checks for silence one pulse before the computed expiry pulse and for the event exactly on it, which separates off-by-one errors in the prescaler from those in the interrupt counter. Pulses given while the prescaler is stopped, and wraps that occur while interrupt-start is clear, must leave the next event's timing unchanged. This shows that each stage's enable gates only its own stage. Count-buffer writes with and without the update flag show whether the flag alone controls the load, while the write-status bit reports both writes.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam logic [7:0] ADDR_RELOAD = 8'h00;
  localparam logic [7:0] ADDR_COUNT  = 8'h08;
  localparam logic [7:0] ADDR_CTRL   = 8'h20;
  localparam logic [7:0] ADDR_STAT   = 8'h30;
  localparam logic [7:0] ADDR_ENABLE = 8'h34;
  localparam logic [7:0] ADDR_WACK   = 8'h40;

  localparam int CTRL_TICK_RUN = 0;
  localparam int CTRL_IRQ_RUN  = 1;
  localparam int CTRL_INTERVAL = 2;
  localparam int COUNT_UPDATE  = 31;

  typedef enum logic [1:0] {
    TGT_NONE   = 2'd0,
    TGT_RELOAD = 2'd1,
    TGT_COUNT  = 2'd2,
    TGT_CTRL   = 2'd3
  } wr_tgt_e;

  typedef struct packed {
    wr_tgt_e     tgt;
    logic [31:0] data;
  } wr_req_t;
endpackage

// File: rtl/tt_wr_delay.sv
module tt_wr_delay
  import tick_timer_pkg::*;
#(
  parameter int DEPTH = 3
) (
  input  logic    clk,
  input  logic    rst_n,
  input  wr_req_t in_req,
  output wr_req_t out_req
);
  wr_req_t stage [DEPTH];

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          stage[i] <= '{tgt: TGT_NONE, data: '0};
        end else if (i == 0) begin
          stage[i] <= in_req;
        end else begin
          stage[i] <= stage[(i == 0) ? 0 : i - 1];
        end
      end
    end
  endgenerate

  assign out_req = stage[DEPTH-1];
endmodule

// File: rtl/tt_prescale.sv
module tt_prescale #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         tick_en,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] reload,
  output logic         wrap
);
  logic [W-1:0] cnt;

  assign wrap = run && tick_en && !load && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reload <= '0;
      cnt    <= '0;
    end else if (load) begin
      reload <= load_val;
      cnt    <= load_val;
    end else if (run && tick_en) begin
      cnt <= (cnt == '0) ? reload : cnt - 1'b1;
    end
  end

  // R5
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> $stable(cnt));

  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= reload);
endmodule

// File: rtl/tt_irq_count.sv
module tt_irq_count #(
  parameter int W = 31
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         run,
  input  logic         interval,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] buffer,
  output logic         expire
);
  logic [W-1:0] cnt;
  logic         last;

  assign last   = (cnt <= W'(1));
  assign expire = step && run && !load && last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buffer <= '0;
      cnt    <= '0;
    end else if (load) begin
      buffer <= load_val;
      cnt    <= load_val;
    end else if (step && run) begin
      if (last) cnt <= interval ? buffer : '0;
      else      cnt <= cnt - 1'b1;
    end
  end

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> $stable(cnt));

  // R8
  interval_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && interval) |=> (cnt == buffer));
endmodule

// File: rtl/core_tick_timer.sv
module core_tick_timer
  import tick_timer_pkg::*;
#(
  parameter int WR_DELAY = 3,
  parameter int TICK_W   = 32,
  parameter int ICNT_W   = 31
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        tick_en,
  output logic        irq
);
  localparam int WACK_BITS = 3;

  wr_req_t    req_in, req_out;
  logic       land_reload, land_count, land_ctrl, count_load;
  logic [2:0] ctrl;
  logic       pend, ien;
  logic [WACK_BITS-1:0] wack;
  logic [TICK_W-1:0]    reload;
  logic [ICNT_W-1:0]    cbuf;
  logic       wrap, expire;

  always_comb begin
    req_in = '{tgt: TGT_NONE, data: bus_wdata};
    if (bus_wr) begin
      case (bus_addr)
        ADDR_RELOAD: req_in.tgt = TGT_RELOAD;
        ADDR_COUNT:  req_in.tgt = TGT_COUNT;
        ADDR_CTRL:   req_in.tgt = TGT_CTRL;
        default:     req_in.tgt = TGT_NONE;
      endcase
    end
  end

  tt_wr_delay #(.DEPTH(WR_DELAY)) u_delay (
    .clk(clk), .rst_n(rst_n), .in_req(req_in), .out_req(req_out)
  );

  assign land_reload = (req_out.tgt == TGT_RELOAD);
  assign land_count  = (req_out.tgt == TGT_COUNT);
  assign land_ctrl   = (req_out.tgt == TGT_CTRL);
  assign count_load  = land_count && req_out.data[COUNT_UPDATE];

  tt_prescale #(.W(TICK_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(ctrl[CTRL_TICK_RUN]), .tick_en(tick_en),
    .load(land_reload), .load_val(req_out.data[TICK_W-1:0]),
    .reload(reload), .wrap(wrap)
  );

  tt_irq_count #(.W(ICNT_W)) u_icnt (
    .clk(clk), .rst_n(rst_n), .step(wrap), .run(ctrl[CTRL_IRQ_RUN]),
    .interval(ctrl[CTRL_INTERVAL]), .load(count_load),
    .load_val(req_out.data[ICNT_W-1:0]), .buffer(cbuf), .expire(expire)
  );

  logic stat_clr, ien_wr, wack_wr;
  assign stat_clr = bus_wr && (bus_addr == ADDR_STAT) && bus_wdata[0];
  assign ien_wr   = bus_wr && (bus_addr == ADDR_ENABLE);
  assign wack_wr  = bus_wr && (bus_addr == ADDR_WACK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0;
      pend <= 1'b0;
      ien  <= 1'b0;
      wack <= '0;
    end else begin
      if (land_ctrl)
        ctrl <= req_out.data[2:0];
      else if (expire && !ctrl[CTRL_INTERVAL])
        ctrl[CTRL_IRQ_RUN] <= 1'b0;
      pend <= (pend && !stat_clr) || expire;
      if (ien_wr) ien <= bus_wdata[0];
      wack <= (wack & ~(wack_wr ? {bus_wdata[3], bus_wdata[1:0]} : 3'b000))
            | {land_ctrl, land_count, land_reload};
    end
  end

  assign irq = pend && ien;

  always_comb begin
    case (bus_addr)
      ADDR_RELOAD: bus_rdata = 32'(reload);
      ADDR_COUNT:  bus_rdata = 32'(cbuf);
      ADDR_CTRL:   bus_rdata = {29'd0, ctrl};
      ADDR_STAT:   bus_rdata = {31'd0, pend};
      ADDR_ENABLE: bus_rdata = {31'd0, ien};
      ADDR_WACK:   bus_rdata = {28'd0, wack[2], 1'b0, wack[1:0]};
      default:     bus_rdata = '0;
    endcase
  end

  // R7
  oneshot_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !ctrl[CTRL_INTERVAL] && !land_ctrl) |=> !ctrl[CTRL_IRQ_RUN]);

  // R6
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> pend);

  // R3
  wack_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wack[0]) |-> $past(req_out.tgt == TGT_RELOAD));

  // R11
  halted_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[CTRL_TICK_RUN] && !ctrl[CTRL_IRQ_RUN]) |-> !expire);
endmodule

// File: tb/core_tick_timer_tb.sv
module core_tick_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DLY = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tick_en = 1'b0;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  core_tick_timer #(.WR_DELAY(DLY)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_en(tick_en), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic settle();
    repeat (DLY) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick_en = 1'b1;
    end
    @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic chk_reg(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic t_reset();
    chk_reg("R1 reload", 8'h00, 0);
    chk_reg("R1 count", 8'h08, 0);
    chk_reg("R1 ctrl", 8'h20, 0);
    chk_reg("R1 stat", 8'h30, 0);
    chk_reg("R1 wack", 8'h40, 0);
    check("R1 irq", {31'd0, irq}, 0);
  endtask

  task automatic t_write_path();
    wr(8'h00, 32'd4);
    chk_reg("R2 reload before landing", 8'h00, 0);
    chk_reg("R3 wack before landing", 8'h40, 0);
    settle();
    chk_reg("R2 reload after landing", 8'h00, 4);
    chk_reg("R3 wack bit0 set", 8'h40, 32'h1);
    wr(8'h40, 32'h0);
    chk_reg("R3 write 0 keeps", 8'h40, 32'h1);
    wr(8'h40, 32'h1);
    chk_reg("R3 write 1 clears", 8'h40, 32'h0);
    wr(8'h20, 32'h0);
    settle();
    chk_reg("R3 wack bit3 on ctrl", 8'h40, 32'h8);
    wr(8'h40, 32'h8);
  endtask

  task automatic t_update_flag();
    wr(8'h08, 32'd5);
    settle();
    chk_reg("R4 no flag ignored", 8'h08, 0);
    chk_reg("R4 wack bit1 set", 8'h40, 32'h2);
    wr(8'h40, 32'h2);
    wr(8'h08, 32'h8000_0002);
    settle();
    chk_reg("R4 flag loads", 8'h08, 2);
  endtask

  task automatic setup(input int rl, input int n, input logic [2:0] c);
    wr(8'h20, 32'h0); settle();
    wr(8'h00, rl); settle();
    wr(8'h08, 32'h8000_0000 | n); settle();
    wr(8'h30, 32'h1);
    wr(8'h40, 32'hB);
    ticks(5);
    wr(8'h20, {29'd0, c}); settle();
  endtask

  task automatic t_oneshot();
    wr(8'h34, 32'h1);
    setup(2, 3, 3'b011);
    ticks(8);
    check("R5 R6 no event before 9th pulse", {31'd0, irq}, 0);
    ticks(1);
    check("R6 R10 event on 9th pulse", {31'd0, irq}, 1);
    chk_reg("R6 stat set", 8'h30, 1);
    chk_reg("R7 irq-start cleared", 8'h20, 32'h1);
    wr(8'h34, 32'h0);
    check("R10 masked", {31'd0, irq}, 0);
    wr(8'h34, 32'h1);
    wr(8'h30, 32'h1);
    chk_reg("R9 stat cleared", 8'h30, 0);
    ticks(20);
    chk_reg("R7 no further event", 8'h30, 0);
    setup(0, 4, 3'b011);
    ticks(3);
    chk_reg("R6 reload 0 count 4 silent", 8'h30, 0);
    ticks(1);
    chk_reg("R6 reload 0 count 4 fires", 8'h30, 1);
  endtask

  task automatic t_interval();
    setup(1, 2, 3'b111);
    ticks(3);
    check("R8 first silent", {31'd0, irq}, 0);
    ticks(1);
    check("R8 first event", {31'd0, irq}, 1);
    wr(8'h30, 32'h1);
    ticks(3);
    check("R8 second silent", {31'd0, irq}, 0);
    ticks(1);
    check("R8 second event", {31'd0, irq}, 1);
    wr(8'h20, 32'h5); settle();
    wr(8'h30, 32'h1);
    ticks(20);
    chk_reg("R6 irq-start clear blocks", 8'h30, 0);
    wr(8'h20, 32'h4); settle();
    ticks(20);
    chk_reg("R11 halted", 8'h30, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_path();
    t_update_flag();
    t_oneshot();
    t_interval();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule